// File: doc/BRIEF.md
# Power Stage Fault Protection Controller

This block is the digital protection manager for a four-half-bridge amplifier output stage. It takes ideal digital flags for supply undervoltage, bootstrap undervoltage and per-half-bridge overcurrent. It also takes an 8-bit junction temperature code in °C, an active-low device reset request and an output configuration select. From these it decides which half-bridges go to high impedance, drives an active-low shutdown flag and produces two active-low overtemperature warnings.

The fault classes behave differently. Supply undervoltage stops all four half-bridges and recovers by itself. Bootstrap undervoltage stops only its own half-bridge. Overtemperature error and overload both latch. A latched fault is released only by a rising edge of the reset request, and that edge is honoured only after a hold-off time has passed since the latch was set. Overload shutdown follows a grouping that depends on the output configuration: in paired-bridge and single-ended modes the pairs A/B and C/D stop together, and in parallel-bridge mode all four stop. Overload and hold-off times are set in milliseconds and converted to cycles from a clock-rate parameter.

All outputs are registered. Each output shows, one clock edge after the inputs are sampled, the state those inputs imply.

Top module: `pstage_guard`

## Requirements
- R1: While `rst_req_n` is low, `hiz` is 4'b1111 and `sd_n` is 1 whatever faults are present. After system reset, `hiz` is 4'b1111 and `sd_n`, `warn_lo_n` and `warn_hi_n` are 1. The warnings keep working while `rst_req_n` is low.
- R2: Any bit of `sup_uv` set puts all four half-bridges in high impedance and drives `sd_n` low on the next edge. Once all bits are clear, operation resumes on the next edge.
- R3: A temperature code of 155 or more latches an overtemperature error: `hiz` is 4'b1111 and `sd_n` is 0. Both stay that way after the temperature falls.
- R4: `oc[i]` must be high for OLP_CYC consecutive edges, where OLP_CYC = CLK_KHZ*OLP_TENTHS_MS/10 (26 by default). On the OLP_CYC-th edge an overload latches for half-bridge i. A shorter burst has no effect, and a low cycle restarts the count.
- R5: In cfg 0 (paired bridge) and cfg 2 (single-ended), an overload in bit 0 or bit 1 (A/B) sets `hiz[1:0]`, and an overload in bit 2 or bit 3 (C/D) sets `hiz[3:2]`.
- R6: In cfg 1 (parallel bridge), and in the unused code 3, an overload in any half-bridge sets all four `hiz` bits.
- R7: `boot_uv[i]` sets only `hiz[i]`, in every configuration, leaves `sd_n` unchanged and recovers by itself.
- R8: A rising edge of `rst_req_n` clears latched faults only if at least HOLD_CYC = CLK_KHZ*HOLD_MS cycles (40 by default) have passed since the latch was set. An earlier rising edge is ignored and the fault stays latched.
- R9: `warn_lo_n` goes low when the temperature is above 100 and returns high only when it is 75 or below.
- R10: `warn_hi_n` goes low when the temperature is above 125 and returns high only when it is 100 or below.
- R11: When undervoltage and a latched fault are both present, `sd_n` stays low until every one of them has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rst_req_n | input | 1 | Device reset request, active low; rising edge releases latched faults |
| cfg | input | 2 | Output configuration: 0 paired, 1 parallel, 2 single-ended |
| sup_uv | input | NSUP | Supply undervoltage flags, one per supply |
| boot_uv | input | 4 | Bootstrap undervoltage flag per half-bridge |
| oc | input | 4 | Overcurrent flag per half-bridge |
| tj | input | TW | Junction temperature code in °C, unsigned |
| hiz | output | 4 | High-impedance enable per half-bridge (bit 0 = A) |
| sd_n | output | 1 | Shutdown flag, active low |
| warn_lo_n | output | 1 | Lower overtemperature warning, active low |
| warn_hi_n | output | 1 | Upper overtemperature warning, active low |

## Verification
A stimulus table walks through supply undervoltage on different supplies, bootstrap undervoltage under two configurations and a rising then falling temperature ramp. The ramp stops exactly on and one step past each warning threshold, so it separates the set edges from the release edges of the hysteresis. Directed runs drive overcurrent bursts one cycle short of the overload limit and exactly at it, with a gap, to show that the counter needs consecutive cycles. Overloads on different half-bridges under all three configurations show the grouping. Reset pulses released before and after the hold-off show that early edges are ignored, and overlapping an overtemperature latch with undervoltage shows that the shutdown flag waits for the last fault.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

   typedef enum logic [1:0] {
      CFG_PAIRED   = 2'd0,
      CFG_PARALLEL = 2'd1,
      CFG_SINGLE   = 2'd2,
      CFG_SPARE    = 2'd3
   } out_cfg_e;

   localparam int unsigned NUM_HB = 4;

   // Expand per-half-bridge overload faults to the set of half-bridges
   // that must stop together for a given output configuration.
   function automatic logic [NUM_HB-1:0] group_spread(
      input out_cfg_e           mode,
      input logic [NUM_HB-1:0]  fault
   );
      logic [NUM_HB-1:0] res;
      res = '0;
      if (mode == CFG_PAIRED || mode == CFG_SINGLE) begin
         for (int p = 0; p < NUM_HB/2; p++) begin
            if (fault[2*p] || fault[2*p+1]) begin
               res[2*p]   = 1'b1;
               res[2*p+1] = 1'b1;
            end
         end
      end else begin
         res = {NUM_HB{|fault}};
      end
      return res;
   endfunction

endpackage

// File: rtl/pstage_olp_timer.sv
module pstage_olp_timer #(
   parameter int unsigned CYC = 26
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic oc,
   output logic trip
);
   localparam int unsigned CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic [CW-1:0] cnt_q;

   // trip on the CYC-th consecutive sampled overcurrent cycle
   assign trip = run && oc && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || !oc) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pstage_thermal.sv
module pstage_thermal #(
   parameter int unsigned TW        = 8,
   parameter int unsigned OTE_C     = 155,
   parameter int unsigned WARN_LO_C = 100,
   parameter int unsigned WARN_HI_C = 125,
   parameter int unsigned HYST_C    = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tj,
   output logic          ote_hit,
   output logic          warn_lo,
   output logic          warn_hi
);
   localparam logic [TW-1:0] OTE_T = TW'(OTE_C);

   logic [1:0] warn_q;

   assign ote_hit = (tj >= OTE_T);

   for (genvar lv = 0; lv < 2; lv++) begin : g_warn
      localparam int unsigned SET_C = (lv == 0) ? WARN_LO_C : WARN_HI_C;
      localparam logic [TW-1:0] SET_T = TW'(SET_C);
      localparam logic [TW-1:0] CLR_T = TW'(SET_C - HYST_C);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            warn_q[lv] <= 1'b0;
         end else if (tj > SET_T) begin
            warn_q[lv] <= 1'b1;
         end else if (tj <= CLR_T) begin
            warn_q[lv] <= 1'b0;
         end
      end
   end

   assign warn_lo = warn_q[0];
   assign warn_hi = warn_q[1];
endmodule

// File: rtl/pstage_latch.sv
module pstage_latch #(
   parameter int unsigned NB   = 4,
   parameter int unsigned HOLD = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rst_req_n,
   input  logic          ote_set,
   input  logic [NB-1:0] olp_set,
   output logic          ote_nx,
   output logic [NB-1:0] olp_nx
);
   localparam int unsigned AW = $clog2(HOLD + 1);
   localparam logic [AW-1:0] HOLD_L = AW'(HOLD);

   logic          rq_q;
   logic          ote_q;
   logic [NB-1:0] olp_q;
   logic [AW-1:0] age_q;
   logic [AW-1:0] age_d;
   logic          clr;
   logic          any_q;
   logic          any_nx;

   // release only on a reset rising edge once the hold-off has elapsed
   assign clr    = rst_req_n && !rq_q && (age_q == HOLD_L);
   assign ote_nx = ote_set | (ote_q & ~clr);
   assign olp_nx = olp_set | (olp_q & {NB{~clr}});
   assign any_q  = ote_q | (|olp_q);
   assign any_nx = ote_nx | (|olp_nx);

   always_comb begin
      age_d = '0;
      if (any_nx && any_q && !clr) begin
         age_d = (age_q == HOLD_L) ? age_q : age_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq_q  <= 1'b0;
         ote_q <= 1'b0;
         olp_q <= '0;
         age_q <= '0;
      end else begin
         rq_q  <= rst_req_n;
         ote_q <= ote_nx;
         olp_q <= olp_nx;
         age_q <= age_d;
      end
   end
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard #(
   parameter int unsigned NSUP          = 5,
   parameter int unsigned TW            = 8,
   parameter int unsigned CLK_KHZ       = 10,
   parameter int unsigned OLP_TENTHS_MS = 26,
   parameter int unsigned HOLD_MS       = 4,
   parameter int unsigned OTE_C         = 155,
   parameter int unsigned WARN_LO_C     = 100,
   parameter int unsigned WARN_HI_C     = 125,
   parameter int unsigned HYST_C        = 25
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rst_req_n,
   input  logic [1:0]      cfg,
   input  logic [NSUP-1:0] sup_uv,
   input  logic [3:0]      boot_uv,
   input  logic [3:0]      oc,
   input  logic [TW-1:0]   tj,
   output logic [3:0]      hiz,
   output logic            sd_n,
   output logic            warn_lo_n,
   output logic            warn_hi_n
);
   import pstage_pkg::*;

   localparam int unsigned NHB      = NUM_HB;
   localparam int unsigned OLP_CYC  = CLK_KHZ * OLP_TENTHS_MS / 10;
   localparam int unsigned HOLD_CYC = CLK_KHZ * HOLD_MS;

   initial begin
      assert (OLP_CYC >= 1) else $error("overload window must be at least one cycle");
      assert (HOLD_CYC >= 1) else $error("hold-off must be at least one cycle");
      assert (WARN_HI_C > WARN_LO_C) else $error("upper warning must exceed lower");
      assert (WARN_LO_C >= HYST_C) else $error("hysteresis larger than warning level");
      assert (OTE_C < (1 << TW)) else $error("error level does not fit temperature code");
      assert (NSUP >= 1) else $error("need at least one supply flag");
   end

   logic [NHB-1:0] olp_trip;
   logic [NHB-1:0] olp_nx;
   logic [NHB-1:0] grouped;
   logic           ote_hit;
   logic           ote_nx;
   logic           warn_lo;
   logic           warn_hi;
   logic           dev_kill;
   logic [NHB-1:0] hiz_d;
   logic           sd_d;
   out_cfg_e       mode;

   assign mode = out_cfg_e'(cfg);

   for (genvar i = 0; i < NHB; i++) begin : g_olp
      pstage_olp_timer #(.CYC(OLP_CYC)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (rst_req_n),
         .oc   (oc[i]),
         .trip (olp_trip[i])
      );
   end

   pstage_thermal #(
      .TW(TW), .OTE_C(OTE_C), .WARN_LO_C(WARN_LO_C),
      .WARN_HI_C(WARN_HI_C), .HYST_C(HYST_C)
   ) u_therm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tj     (tj),
      .ote_hit(ote_hit),
      .warn_lo(warn_lo),
      .warn_hi(warn_hi)
   );

   pstage_latch #(.NB(NHB), .HOLD(HOLD_CYC)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_req_n(rst_req_n),
      .ote_set  (ote_hit),
      .olp_set  (olp_trip),
      .ote_nx   (ote_nx),
      .olp_nx   (olp_nx)
   );

   assign grouped  = group_spread(mode, olp_nx);
   assign dev_kill = (|sup_uv) | ote_nx;

   always_comb begin
      if (!rst_req_n) begin
         hiz_d = '1;
         sd_d  = 1'b1;
      end else begin
         hiz_d = {NHB{dev_kill}} | grouped | boot_uv;
         sd_d  = !(dev_kill || (|olp_nx));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hiz  <= '1;
         sd_n <= 1'b1;
      end else begin
         hiz  <= hiz_d;
         sd_n <= sd_d;
      end
   end

   assign warn_lo_n = ~warn_lo;
   assign warn_hi_n = ~warn_hi;
endmodule

// File: rtl/pstage_guard_chk.sv
module pstage_guard_chk #(
   parameter int unsigned NSUP      = 5,
   parameter int unsigned TW        = 8,
   parameter int unsigned OTE_C     = 155,
   parameter int unsigned WARN_LO_C = 100,
   parameter int unsigned WARN_HI_C = 125,
   parameter int unsigned HYST_C    = 25
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rst_req_n,
   input logic [NSUP-1:0] sup_uv,
   input logic [3:0]      boot_uv,
   input logic [TW-1:0]   tj,
   input logic [3:0]      hiz,
   input logic            sd_n,
   input logic            warn_lo_n,
   input logic            warn_hi_n
);
   p_rst_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req_n |=> (hiz == 4'hF && sd_n));

   p_uv_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_n && (|sup_uv)) |=> (hiz == 4'hF && !sd_n));

   p_ote_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_n && (int'(tj) >= OTE_C)) |=> (hiz == 4'hF && !sd_n));

   p_boot_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|boot_uv) |=> ((hiz & $past(boot_uv)) == $past(boot_uv)));

   p_warn_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tj) > WARN_LO_C) |=> !warn_lo_n);

   p_warn_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!warn_lo_n && int'(tj) > WARN_LO_C - HYST_C) |=> !warn_lo_n);

   p_warn_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tj) > WARN_HI_C) |=> !warn_hi_n);

   p_sd_has_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_n |-> (hiz != 4'h0));
endmodule

bind pstage_guard pstage_guard_chk #(
   .NSUP(NSUP), .TW(TW), .OTE_C(OTE_C), .WARN_LO_C(WARN_LO_C),
   .WARN_HI_C(WARN_HI_C), .HYST_C(HYST_C)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_req_n(rst_req_n),
   .sup_uv   (sup_uv),
   .boot_uv  (boot_uv),
   .tj       (tj),
   .hiz      (hiz),
   .sd_n     (sd_n),
   .warn_lo_n(warn_lo_n),
   .warn_hi_n(warn_hi_n)
);

// File: tb/sim_pstage_guard.sv
module sim_pstage_guard;

   localparam int OLP  = 26;  // 10 kHz * 2.6 ms
   localparam int HOLD = 40;  // 10 kHz * 4 ms

   typedef struct packed {
      logic [1:0] cfg;
      logic [4:0] sup;
      logic [3:0] boot;
      logic [7:0] tj;
      logic [3:0] hiz;
      logic       sd;
      logic       wlo;
      logic       whi;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 5'b00000, 4'b0000, 8'd25,  4'h0, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b00001, 4'b0000, 8'd25,  4'hF, 1'b0, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd25,  4'h0, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b10000, 4'b0000, 8'd25,  4'hF, 1'b0, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0010, 8'd25,  4'h2, 1'b1, 1'b1, 1'b1},
      '{2'd1, 5'b00000, 4'b1000, 8'd25,  4'h8, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd100, 4'h0, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd101, 4'h0, 1'b1, 1'b0, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd76,  4'h0, 1'b1, 1'b0, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd75,  4'h0, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd126, 4'h0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 5'b00000, 4'b0000, 8'd101, 4'h0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 5'b00000, 4'b0000, 8'd100, 4'h0, 1'b1, 1'b0, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd60,  4'h0, 1'b1, 1'b1, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd125, 4'h0, 1'b1, 1'b0, 1'b1},
      '{2'd0, 5'b00000, 4'b0000, 8'd25,  4'h0, 1'b1, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rst_req_n;
   logic [1:0] cfg;
   logic [4:0] sup_uv;
   logic [3:0] boot_uv;
   logic [3:0] oc;
   logic [7:0] tj;
   logic [3:0] hiz;
   logic       sd_n;
   logic       warn_lo_n;
   logic       warn_hi_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pstage_guard u0 (
      .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .cfg(cfg),
      .sup_uv(sup_uv), .boot_uv(boot_uv), .oc(oc), .tj(tj),
      .hiz(hiz), .sd_n(sd_n), .warn_lo_n(warn_lo_n), .warn_hi_n(warn_hi_n)
   );

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [3:0] hiz_e, logic sd_e,
                        logic wlo_e, logic whi_e);
      n_chk++;
      if (hiz !== hiz_e || sd_n !== sd_e || warn_lo_n !== wlo_e || warn_hi_n !== whi_e) begin
         n_fail++;
         $display("FAIL %s: hiz=%b sd_n=%b wlo=%b whi=%b expected hiz=%b sd_n=%b wlo=%b whi=%b",
                  req, hiz, sd_n, warn_lo_n, warn_hi_n, hiz_e, sd_e, wlo_e, whi_e);
      end
   endtask

   // reset pulse long enough to pass the hold-off, then release
   task automatic release_all();
      rst_req_n = 1'b0;
      step(HOLD + 2);
      rst_req_n = 1'b1;
      step(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rst_req_n = 1'b0; cfg = 2'd0;
      sup_uv = '0; boot_uv = '0; oc = '0; tj = 8'd25;
      step(3);
      rst_n = 1'b1;
      check("R1 reset state", 4'hF, 1'b1, 1'b1, 1'b1);

      // R1: reset request low masks faults, warnings still live
      sup_uv = 5'b00010; tj = 8'd110;
      step(1);
      check("R1 held", 4'hF, 1'b1, 1'b0, 1'b1);
      sup_uv = '0; tj = 8'd25;
      step(1);
      rst_req_n = 1'b1;
      step(1);
      check("R1 run", 4'h0, 1'b1, 1'b1, 1'b1);

      // table walk: undervoltage, bootstrap, warning hysteresis (R2 R7 R9 R10)
      for (int k = 0; k < NV; k++) begin
         cfg = TBL[k].cfg; sup_uv = TBL[k].sup; boot_uv = TBL[k].boot; tj = TBL[k].tj;
         step(1);
         check($sformatf("R2/R7/R9/R10 vec %0d", k), TBL[k].hiz, TBL[k].sd, TBL[k].wlo, TBL[k].whi);
      end
      cfg = 2'd0; sup_uv = '0; boot_uv = '0; tj = 8'd25;
      step(1);

      // R4: bursts one short of the window, with a gap, do nothing
      oc = 4'b0001; step(OLP - 1);
      check("R4 short burst", 4'h0, 1'b1, 1'b1, 1'b1);
      oc = 4'b0000; step(1);
      oc = 4'b0001; step(OLP - 1);
      check("R4 restart after gap", 4'h0, 1'b1, 1'b1, 1'b1);
      step(1);
      check("R4 R5 trip pair AB", 4'h3, 1'b0, 1'b1, 1'b1);
      oc = 4'b0000; step(3);
      check("R4 latched", 4'h3, 1'b0, 1'b1, 1'b1);

      // R8: early release ignored
      rst_req_n = 1'b0; step(2);
      check("R1 during pulse", 4'hF, 1'b1, 1'b1, 1'b1);
      rst_req_n = 1'b1; step(1);
      check("R8 early edge ignored", 4'h3, 1'b0, 1'b1, 1'b1);
      release_all();
      check("R8 release after hold-off", 4'h0, 1'b1, 1'b1, 1'b1);

      // R6: parallel configuration stops all
      cfg = 2'd1; oc = 4'b0100; step(OLP);
      check("R6 parallel trip", 4'hF, 1'b0, 1'b1, 1'b1);
      oc = '0; release_all();
      check("R6 release", 4'h0, 1'b1, 1'b1, 1'b1);

      // R5: single-ended pairs C/D
      cfg = 2'd2; oc = 4'b1000; step(OLP);
      check("R5 single-ended CD", 4'hC, 1'b0, 1'b1, 1'b1);
      oc = '0; release_all();
      cfg = 2'd0;

      // R3: overtemperature latch
      tj = 8'd160; step(1);
      check("R3 ote trip", 4'hF, 1'b0, 1'b0, 1'b0);
      tj = 8'd25; step(1);
      check("R3 ote latched", 4'hF, 1'b0, 1'b1, 1'b1);
      release_all();
      check("R3 ote released", 4'h0, 1'b1, 1'b1, 1'b1);

      // R11: latch plus undervoltage
      tj = 8'd155; step(1);
      tj = 8'd25; sup_uv = 5'b00100; step(1);
      release_all();
      check("R11 uv still active", 4'hF, 1'b0, 1'b1, 1'b1);
      sup_uv = '0; step(1);
      check("R11 all clear", 4'h0, 1'b1, 1'b1, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule